// File: doc/BRIEF.md
# CPU Processing State Controller

This block is the state keeper for a small microcontroller core. It records which of seven processing states the core is in and drives enables from that state. The states are RESET, EXCEPT (exception handling), RUN (program execution), BUSREL (bus released to another master), SLEEP, SWSTBY (software standby) and HWSTBY (hardware standby). The instruction decoder, the vector fetch and the oscillator are outside the block. They see the result as a one-hot state code, a clock enable, a bus grant and an enable for the exception sequencer.

Two asynchronous pins, reset and standby, are both active low. Each passes through a synchronizer that asserts at once and releases after two clocks. Standby has the highest priority: it takes the core into HWSTBY from anywhere. The only way out of HWSTBY is into RESET, with standby high and reset still low. Reset, or a one-cycle watchdog overflow pulse, forces RESET from every other state. After a pin reset, the synchronized rising edge of reset starts exception handling. After a watchdog overflow, exception handling starts once RESET has been held for 16 cycles.

The ordinary transitions are:
- EXCEPT goes to RUN on the exception-done strobe.
- RUN goes to EXCEPT on any interrupt.
- A sleep strobe in RUN goes to SWSTBY or SLEEP, chosen by the standby-select bit.
- SLEEP wakes on any interrupt.
- SWSTBY wakes only on an external interrupt.
- A bus request in RUN or EXCEPT parks the core in BUSREL until the request drops, then returns to the state it came from.

Top module: `proc_state_ctrl`

## Requirements
- R1: With the synchronized reset low and standby high, the state after the next clock edge is RESET from any state other than HWSTBY. In RESET, clk_en is 1, bus_grant is 0 and exc_seq_en is 0.
- R2: A low standby pin gives HWSTBY after the next clock edge from any state, even while reset is low. clk_en is 0 in HWSTBY.
- R3: HWSTBY is left only for RESET, when synchronized standby is high and synchronized reset is low. While reset stays high it remains in HWSTBY, and watchdog pulses there have no effect.
- R4: Pin deassertion passes two synchronizer flops. After the reset pin rises in RESET, the state is still RESET after the second edge and EXCEPT after the third. After the standby pin rises with reset low, HWSTBY holds for two edges and RESET follows on the third.
- R5: A watchdog pulse, accepted outside HWSTBY with both pins high, gives RESET after the next edge. The state stays RESET for exactly 16 cycles and is EXCEPT after the 16th following edge.
- R6: In EXCEPT, the exception-done strobe moves to RUN. In RUN, any external or internal interrupt moves to EXCEPT.
- R7: A sleep strobe in RUN moves to SWSTBY when ssby_sel is 1 and to SLEEP when it is 0. An interrupt in the same cycle wins, and the state goes to EXCEPT.
- R8: SLEEP moves to EXCEPT on any external or internal interrupt. clk_en stays 1 in SLEEP.
- R9: SWSTBY moves to EXCEPT only on an external interrupt and ignores internal ones. clk_en is 0 in SWSTBY.
- R10: bus_req in RUN or EXCEPT moves to BUSREL with bus_grant 1. It wins over exc_done, interrupts and the sleep strobe. When bus_req drops, the state returns to the one it came from.
- R11: state_code is one-hot with bit 0 RESET, 1 EXCEPT, 2 RUN, 3 BUSREL, 4 SLEEP, 5 SWSTBY, 6 HWSTBY. exc_seq_en is 1 only in EXCEPT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| stby_pin_n | input | 1 | Asynchronous hardware standby pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow, one-cycle pulse |
| sleep_stb | input | 1 | Sleep instruction strobe |
| ssby_sel | input | 1 | Standby select: 1 software standby, 0 sleep |
| irq_ext | input | N_EXT_IRQ | External interrupt requests |
| irq_int | input | N_INT_IRQ | Internal peripheral interrupt requests |
| bus_req | input | 1 | External master bus request, held while wanted |
| exc_done | input | 1 | Exception sequence finished strobe |
| state_code | output | 7 | One-hot processing state |
| clk_en | output | 1 | Core clock enable |
| bus_grant | output | 1 | Bus released to external master |
| exc_seq_en | output | 1 | Exception sequencer enable |

## Verification
Synchronous inputs act on the first edge after they are presented. Pin assertion acts on the next edge because the synchronizers clear asynchronously. Pin release takes three edges: two synchronizer flops and then the state update. A watchdog entry into RESET lasts sixteen edges. The bench presents each stimulus just after an edge, counts the edges to the one where the result is due, and samples two time units after that edge. Edges that should leave the state unchanged are sampled too.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

    localparam int PS_COUNT = 7;

    typedef enum logic [PS_COUNT-1:0] {
        PS_RESET  = 7'b0000001,
        PS_EXCEPT = 7'b0000010,
        PS_RUN    = 7'b0000100,
        PS_BUSREL = 7'b0001000,
        PS_SLEEP  = 7'b0010000,
        PS_SWSTBY = 7'b0100000,
        PS_HWSTBY = 7'b1000000
    } pstate_e;

    // Clock keeps running everywhere except the two standby states.
    function automatic logic clock_kept(input pstate_e s);
        return !(s == PS_SWSTBY || s == PS_HWSTBY);
    endfunction

endpackage

// File: rtl/pstate_sync.sv
module pstate_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] sync_n
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Assert at once, release through STAGES flops.
        always_ff @(posedge clk or negedge pin_n[g]) begin
            if (!pin_n[g]) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], 1'b1};
            end
        end

        assign sync_n[g] = chain[STAGES-1];

        // R4
        sync_rise_chk: assert property (@(posedge clk) disable iff (!pin_n[g])
            $rose(sync_n[g]) |-> $past(pin_n[g]));
    end

endmodule

// File: rtl/pstate_wdt_hold.sv
module pstate_wdt_hold #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic load,
    input  logic clear,
    output logic done
);

    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (clear) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= CW'(HOLD - 1);
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = active && (cnt == '0);

    // R5
    hold_single_chk: assert property (@(posedge clk) disable iff (clear)
        (done && !load) |=> !done);

endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
    import pstate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_s_n,
    input  logic                stby_s_n,
    input  logic                wdt_ovf,
    input  logic                sleep_stb,
    input  logic                ssby_sel,
    input  logic                irq_ext_any,
    input  logic                irq_int_any,
    input  logic                bus_req,
    input  logic                exc_done,
    input  logic                hold_done,
    output logic                hold_load,
    output logic                hold_clear,
    output logic [PS_COUNT-1:0] state_code,
    output logic                clk_en,
    output logic                bus_grant,
    output logic                exc_seq_en
);

    pstate_e state;
    pstate_e state_nx;
    logic    rst_q;
    logic    ret_run;
    logic    ret_run_nx;
    logic    rst_rise;
    logic    wdt_take;
    logic    irq_any;

    assign rst_rise   = rst_s_n && !rst_q;
    assign irq_any    = irq_ext_any || irq_int_any;
    assign wdt_take   = wdt_ovf && rst_s_n && stby_s_n && (state != PS_HWSTBY);
    assign hold_load  = wdt_take;
    assign hold_clear = !rst_s_n || !stby_s_n;

    // State register
    always_ff @(posedge clk) begin
        state   <= state_nx;
        rst_q   <= rst_s_n;
        ret_run <= ret_run_nx;
    end

    // Next-state logic: standby, then reset, then watchdog, then per state
    always_comb begin
        state_nx   = state;
        ret_run_nx = ret_run;
        if (!stby_s_n) begin
            state_nx = PS_HWSTBY;
        end else if (state == PS_HWSTBY) begin
            if (!rst_s_n) begin
                state_nx = PS_RESET;
            end
        end else if (!rst_s_n || wdt_take) begin
            state_nx = PS_RESET;
        end else begin
            unique case (state)
                PS_RESET: begin
                    if (rst_rise || hold_done) begin
                        state_nx = PS_EXCEPT;
                    end
                end
                PS_EXCEPT: begin
                    if (bus_req) begin
                        state_nx   = PS_BUSREL;
                        ret_run_nx = 1'b0;
                    end else if (exc_done) begin
                        state_nx = PS_RUN;
                    end
                end
                PS_RUN: begin
                    if (bus_req) begin
                        state_nx   = PS_BUSREL;
                        ret_run_nx = 1'b1;
                    end else if (irq_any) begin
                        state_nx = PS_EXCEPT;
                    end else if (sleep_stb) begin
                        state_nx = ssby_sel ? PS_SWSTBY : PS_SLEEP;
                    end
                end
                PS_BUSREL: begin
                    if (!bus_req) begin
                        state_nx = ret_run ? PS_RUN : PS_EXCEPT;
                    end
                end
                PS_SLEEP: begin
                    if (irq_any) begin
                        state_nx = PS_EXCEPT;
                    end
                end
                PS_SWSTBY: begin
                    if (irq_ext_any) begin
                        state_nx = PS_EXCEPT;
                    end
                end
                PS_HWSTBY: begin
                    state_nx = PS_HWSTBY;
                end
                default: begin
                    state_nx = PS_RESET;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        state_code = state;
        clk_en     = clock_kept(state);
        bus_grant  = 1'b0;
        exc_seq_en = 1'b0;
        unique case (state)
            PS_BUSREL: bus_grant  = 1'b1;
            PS_EXCEPT: exc_seq_en = 1'b1;
            default: ;
        endcase
    end

    // R2
    stby_wins_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
        !stby_s_n |=> state == PS_HWSTBY);

    // R1
    reset_entry_chk: assert property (@(posedge clk) disable iff (!stby_s_n)
        (!rst_s_n && state != PS_HWSTBY) |=> state == PS_RESET);

    // R3
    hw_hold_chk: assert property (@(posedge clk) disable iff (!stby_s_n)
        (state == PS_HWSTBY && rst_s_n) |=> state == PS_HWSTBY);

    // R7
    sleep_pick_chk: assert property (@(posedge clk) disable iff (!rst_s_n || !stby_s_n)
        (state == PS_RUN && sleep_stb && !bus_req && !irq_any && !wdt_ovf)
        |=> state == ($past(ssby_sel) ? PS_SWSTBY : PS_SLEEP));

    // R9
    swstby_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s_n || !stby_s_n)
        (state == PS_SWSTBY && !irq_ext_any && !wdt_ovf) |=> state == PS_SWSTBY);

    // R10
    bus_enter_chk: assert property (@(posedge clk) disable iff (!rst_s_n || !stby_s_n)
        ((state == PS_RUN || state == PS_EXCEPT) && bus_req && !wdt_ovf) |=> bus_grant);

    // R11
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
        $countones(state_code) == 1);

endmodule

// File: rtl/proc_state_ctrl.sv
module proc_state_ctrl
    import pstate_pkg::*;
#(
    parameter int N_EXT_IRQ   = 2,
    parameter int N_INT_IRQ   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WDT_HOLD    = 16
) (
    input  logic                 clk,
    input  logic                 rst_pin_n,
    input  logic                 stby_pin_n,
    input  logic                 wdt_ovf,
    input  logic                 sleep_stb,
    input  logic                 ssby_sel,
    input  logic [N_EXT_IRQ-1:0] irq_ext,
    input  logic [N_INT_IRQ-1:0] irq_int,
    input  logic                 bus_req,
    input  logic                 exc_done,
    output logic [PS_COUNT-1:0]  state_code,
    output logic                 clk_en,
    output logic                 bus_grant,
    output logic                 exc_seq_en
);

    localparam int PIN_COUNT = 2;

    logic [PIN_COUNT-1:0] pins_n;
    logic [PIN_COUNT-1:0] pins_s_n;
    logic                 rst_s_n;
    logic                 stby_s_n;
    logic                 hold_load;
    logic                 hold_clear;
    logic                 hold_done;

    assign pins_n   = {stby_pin_n, rst_pin_n};
    assign rst_s_n  = pins_s_n[0];
    assign stby_s_n = pins_s_n[1];

    pstate_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .pin_n  (pins_n),
        .sync_n (pins_s_n)
    );

    pstate_wdt_hold #(
        .HOLD (WDT_HOLD)
    ) u_hold (
        .clk   (clk),
        .load  (hold_load),
        .clear (hold_clear),
        .done  (hold_done)
    );

    pstate_fsm u_fsm (
        .clk         (clk),
        .rst_s_n     (rst_s_n),
        .stby_s_n    (stby_s_n),
        .wdt_ovf     (wdt_ovf),
        .sleep_stb   (sleep_stb),
        .ssby_sel    (ssby_sel),
        .irq_ext_any (|irq_ext),
        .irq_int_any (|irq_int),
        .bus_req     (bus_req),
        .exc_done    (exc_done),
        .hold_done   (hold_done),
        .hold_load   (hold_load),
        .hold_clear  (hold_clear),
        .state_code  (state_code),
        .clk_en      (clk_en),
        .bus_grant   (bus_grant),
        .exc_seq_en  (exc_seq_en)
    );

    // R5
    wdt_entry_chk: assert property (@(posedge clk) disable iff (!rst_s_n || !stby_s_n)
        (wdt_ovf && state_code != PS_HWSTBY) |=> state_code == PS_RESET);

endmodule

// File: tb/proc_state_ctrl_test.sv
module proc_state_ctrl_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [6:0] S_RST = 7'h01;
    localparam logic [6:0] S_EXC = 7'h02;
    localparam logic [6:0] S_RUN = 7'h04;
    localparam logic [6:0] S_BUS = 7'h08;
    localparam logic [6:0] S_SLP = 7'h10;
    localparam logic [6:0] S_SSB = 7'h20;
    localparam logic [6:0] S_HSB = 7'h40;

    // {bus_req, irq_ext[1:0], irq_int[1:0], sleep, ssby, exc_done, wdt, expected}
    localparam int NVEC = 22;
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, S_RUN}, // R6
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_RUN},
        {1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, S_EXC}, // R6
        {1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_BUS}, // R10
        {1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_BUS},
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_EXC}, // R10 back
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, S_RUN},
        {1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_BUS},
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_RUN}, // R10 back
        {1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, S_SLP}, // R7
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_SLP}, // R8
        {1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, S_EXC}, // R8
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, S_RUN},
        {1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, S_SSB}, // R7
        {1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, S_SSB}, // R9
        {1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_EXC}, // R9
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, S_RUN},
        {1'b0, 2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, S_EXC}, // R7 irq wins
        {1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, S_BUS}, // R10 wins
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, S_EXC},
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, S_RUN},
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, S_RST}  // R5
    };

    logic       clk = 1'b0;
    logic       rst_pin_n, stby_pin_n, wdt_ovf, sleep_stb, ssby_sel;
    logic [1:0] irq_ext, irq_int;
    logic       bus_req, exc_done;
    logic [6:0] state_code;
    logic       clk_en, bus_grant, exc_seq_en;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    proc_state_ctrl uut (
        .clk        (clk),
        .rst_pin_n  (rst_pin_n),
        .stby_pin_n (stby_pin_n),
        .wdt_ovf    (wdt_ovf),
        .sleep_stb  (sleep_stb),
        .ssby_sel   (ssby_sel),
        .irq_ext    (irq_ext),
        .irq_int    (irq_int),
        .bus_req    (bus_req),
        .exc_done   (exc_done),
        .state_code (state_code),
        .clk_en     (clk_en),
        .bus_grant  (bus_grant),
        .exc_seq_en (exc_seq_en)
    );

    // {code, clk_en, bus_grant, exc_seq_en} from R2, R9, R10, R11
    function automatic logic [9:0] expect_of(input logic [6:0] code);
        return {code, ~(code[5] | code[6]), code[3], code[1]};
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        logic [9:0] act;
        act = {state_code, clk_en, bus_grant, exc_seq_en};
        n_chk++;
        if (act !== expect_of(exp)) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, expect_of(exp));
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic quiet();
        wdt_ovf = 1'b0; sleep_stb = 1'b0; ssby_sel = 1'b0;
        irq_ext = '0; irq_int = '0; bus_req = 1'b0; exc_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got no completion, expected finish");
        finish_run();
    end

    initial begin
        quiet();
        rst_pin_n  = 1'b0;
        stby_pin_n = 1'b1;
        step(3);
        check("R1 reset state", S_RST);

        rst_pin_n = 1'b1;
        step(2);
        check("R4 reset release second edge", S_RST);
        step(1);
        check("R4 reset release third edge", S_EXC);

        for (int i = 0; i < NVEC; i++) begin
            bus_req   = VEC[i][15];
            irq_ext   = VEC[i][14:13];
            irq_int   = VEC[i][12:11];
            sleep_stb = VEC[i][10];
            ssby_sel  = VEC[i][9];
            exc_done  = VEC[i][8];
            wdt_ovf   = VEC[i][7];
            step(1);
            check($sformatf("table row %0d (R5 R6 R7 R8 R9 R10)", i), VEC[i][6:0]);
        end
        quiet();

        step(15);
        check("R5 watchdog hold cycle 16", S_RST);
        step(1);
        check("R5 watchdog hold done", S_EXC);

        exc_done = 1'b1; step(1); exc_done = 1'b0;
        check("R6 exception done", S_RUN);

        rst_pin_n = 1'b0;
        step(1);
        check("R1 reset from run", S_RST);
        step(2);
        check("R1 reset held", S_RST);

        stby_pin_n = 1'b0;
        step(1);
        check("R2 standby over reset", S_HSB);

        stby_pin_n = 1'b1;
        step(2);
        check("R4 standby release second edge", S_HSB);
        step(1);
        check("R3 standby exit to reset", S_RST);

        rst_pin_n = 1'b1;
        step(3);
        check("R4 reset release after standby", S_EXC);

        exc_done = 1'b1; step(1); exc_done = 1'b0;
        check("R6 exception done again", S_RUN);

        stby_pin_n = 1'b0;
        step(1);
        check("R2 standby from run", S_HSB);

        stby_pin_n = 1'b1;
        step(3);
        wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
        step(2);
        check("R3 standby held with reset high and watchdog", S_HSB);

        rst_pin_n = 1'b0;
        step(1);
        check("R3 reset low leaves standby", S_RST);

        rst_pin_n = 1'b1;
        step(3);
        check("R4 release to exception", S_EXC);

        bus_req = 1'b1;
        step(1);
        check("R10 bus from exception", S_BUS);
        rst_pin_n = 1'b0;
        step(1);
        check("R1 reset from bus released", S_RST);
        bus_req = 1'b0;

        finish_run();
    end

endmodule